// File: doc/BRIEF.md
# Stop-Clock Grant Controller

This block sequences a processor's reaction to an external stop-clock request. When the request arrives while the core is running or halted, the bus side issues one acknowledge special cycle for each die, one after another. It waits for the bus to report the response phase of each cycle. After the response phase of the last acknowledge, the controller counts a fixed number of bus clocks and then enters the grant state, where the core clocks may be stopped.

While parked in the grant state, the controller services bus snoops through a short snoop state and returns to grant afterwards. Interrupt-class events (SMI, INIT and the two local interrupt lines) that arrive after the request are held back and collapsed into one flag per event. The flags are handed out for a single clock once the request is withdrawn and the controller has returned to the state it left, running or halted. A withdrawal before grant is reached breaks the protocol and is flagged. A reset while parked reinitialises the controller but keeps it parked.

Top module: `stopclk_ctrl`

## Requirements
- R1: After a reset outside the grant and snoop states, `state_code` is 0 (running), and `ack_req`, `proto_err` and `evt_pend` are all 0.
- R2: With no stop request, `state_code` follows `halted` one clock later: 0 when running, 1 when halted.
- R3: A stop request seen in state 0 or 1 moves `state_code` to 2 (stopping) on the next clock. On that clock `ack_req` pulses for one cycle with `ack_die` = 0. Each further die's acknowledge (`ack_die` = 1, 2, ...) pulses for one cycle, on the clock after the edge that samples `rsp_phase` for the previous die.
- R4: `state_code` becomes 3 (grant) exactly `GRANT_DELAY` clock edges after the edge that samples `rsp_phase` for the last die's acknowledge.
- R5: Dropping `stop_req` while in state 2 sets `proto_err`. It stays set until reset.
- R6: In state 3, dropping `stop_req` (with no snoop) returns to the state held when the request was taken: 0 or 1.
- R7: `snoop_hit` in state 3 gives state 4 (snoop service) for exactly one clock, then state 3 again. A snoop takes priority over a release in the same cycle.
- R8: Events on `evt_in` are latched during states 2, 3 and 4. The bit order is bit0 SMI, bit1 INIT, bit2 LINT0, bit3 LINT1. They appear on `evt_pend` for exactly one clock, together with the return to state 0 or 1. Each event gives one flag, however many pulses it had.
- R9: Events on `evt_in` in states 0 and 1 leave `evt_pend` at 0.
- R10: A reset in state 3 keeps `state_code` at 3 and clears `proto_err` and the latched events. The return point becomes state 0, so a later release yields state 0 with `evt_pend` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | External stop-clock request, active high |
| halted | input | 1 | Core is halted (selects idle state 1) |
| rsp_phase | input | 1 | Response phase of the outstanding acknowledge cycle |
| snoop_hit | input | 1 | A bus snoop was detected |
| evt_in | input | 4 | SMI, INIT, LINT0, LINT1 event lines |
| ack_req | output | 1 | Request to issue one acknowledge special cycle |
| ack_die | output | DIE_W | Die the acknowledge cycle belongs to |
| state_code | output | 3 | 0 run, 1 halt, 2 stopping, 3 grant, 4 snoop |
| proto_err | output | 1 | Sticky early-release violation flag |
| evt_pend | output | 4 | Pending-event flags, valid for one clock on return |

## Verification
The bench builds the block with two dies and a delay of 20 clocks, the default values. With these values it walks the full two-acknowledge sequence and counts the whole delay window edge by edge, so an off-by-one in the counter shows up in the exact clock checked. Random response latencies, snoop counts, event masks and early releases are mixed with directed cases. These directed cases cover a snoop at the moment of release, a reset while parked, and events repeated during grant.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL   = 3'd0,
        ST_HALT     = 3'd1,
        ST_STOPPING = 3'd2,
        ST_GRANT    = 3'd3,
        ST_SNOOP    = 3'd4
    } sc_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAITRSP,
        SQ_COUNT
    } seq_phase_e;

    localparam int EVT_SMI   = 0;
    localparam int EVT_INIT  = 1;
    localparam int EVT_LINT0 = 2;
    localparam int EVT_LINT1 = 3;
    localparam int NUM_EVT   = 4;

    function automatic logic is_idle(sc_state_e s);
        return (s == ST_NORMAL) || (s == ST_HALT);
    endfunction

    function automatic logic is_parked(sc_state_e s);
        return (s == ST_GRANT) || (s == ST_SNOOP);
    endfunction

    function automatic sc_state_e idle_of(logic hlt);
        return hlt ? ST_HALT : ST_NORMAL;
    endfunction

endpackage

// File: rtl/stopclk_ackseq.sv
module stopclk_ackseq
    import stopclk_pkg::*;
#(
    parameter int NUM_DIE     = 2,
    parameter int GRANT_DELAY = 20,
    localparam int DIE_W      = (NUM_DIE > 1) ? $clog2(NUM_DIE) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rsp_phase,
    output logic             ack_req,
    output logic [DIE_W-1:0] ack_die,
    output logic             grant_go
);
    localparam int CNT_W = $clog2(GRANT_DELAY + 1);
    localparam logic [DIE_W-1:0] LAST_DIE   = DIE_W'(NUM_DIE - 1);
    localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(GRANT_DELAY - 1);

    seq_phase_e       phase_q;
    logic [DIE_W-1:0] die_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= SQ_IDLE;
            die_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                SQ_IDLE: if (start) begin
                    phase_q <= SQ_ISSUE;
                    die_q   <= '0;
                end
                SQ_ISSUE: phase_q <= SQ_WAITRSP;
                SQ_WAITRSP: if (rsp_phase) begin
                    if (die_q == LAST_DIE) begin
                        phase_q <= SQ_COUNT;
                        cnt_q   <= '0;
                    end else begin
                        phase_q <= SQ_ISSUE;
                        die_q   <= die_q + 1'b1;
                    end
                end
                SQ_COUNT: begin
                    if (cnt_q == DELAY_LAST) phase_q <= SQ_IDLE;
                    else                     cnt_q   <= cnt_q + 1'b1;
                end
                default: phase_q <= SQ_IDLE;
            endcase
        end
    end

    assign ack_req  = (phase_q == SQ_ISSUE);
    assign ack_die  = die_q;
    assign grant_go = (phase_q == SQ_COUNT) && (cnt_q == DELAY_LAST);

endmodule

// File: rtl/stopclk_evtlatch.sv
module stopclk_evtlatch #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         present,
    input  logic [N-1:0] evt_in,
    output logic [N-1:0] evt_pend
);
    for (genvar i = 0; i < N; i++) begin : g_evt
        logic held_q;
        logic pend_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                held_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                pend_q <= present & held_q;
                if (present)
                    held_q <= 1'b0;
                else if (capture && evt_in[i])
                    held_q <= 1'b1;
            end
        end

        assign evt_pend[i] = pend_q;
    end

endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
    import stopclk_pkg::*;
#(
    parameter int NUM_DIE     = 2,
    parameter int GRANT_DELAY = 20,
    localparam int DIE_W      = (NUM_DIE > 1) ? $clog2(NUM_DIE) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_req,
    input  logic             halted,
    input  logic             rsp_phase,
    input  logic             snoop_hit,
    input  logic [3:0]       evt_in,
    output logic             ack_req,
    output logic [DIE_W-1:0] ack_die,
    output logic [2:0]       state_code,
    output logic             proto_err,
    output logic [3:0]       evt_pend
);
    sc_state_e state_q;
    logic      ret_halt_q;
    logic      proto_q;
    logic      grant_go;
    logic      start_w;
    logic      present_w;
    logic      capture_w;

    assign start_w   = is_idle(state_q) && stop_req;
    assign present_w = (state_q == ST_GRANT) && !snoop_hit && !stop_req;
    assign capture_w = !is_idle(state_q);

    stopclk_ackseq #(
        .NUM_DIE    (NUM_DIE),
        .GRANT_DELAY(GRANT_DELAY)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_w),
        .rsp_phase(rsp_phase),
        .ack_req  (ack_req),
        .ack_die  (ack_die),
        .grant_go (grant_go)
    );

    stopclk_evtlatch #(.N(NUM_EVT)) u_evt (
        .clk     (clk),
        .rst     (rst),
        .capture (capture_w),
        .present (present_w),
        .evt_in  (evt_in),
        .evt_pend(evt_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            if (is_parked(state_q)) state_q <= ST_GRANT;
            else                    state_q <= ST_NORMAL;
            ret_halt_q <= 1'b0;
            proto_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_NORMAL, ST_HALT: begin
                    if (stop_req) begin
                        state_q    <= ST_STOPPING;
                        ret_halt_q <= (state_q == ST_HALT);
                    end else begin
                        state_q <= idle_of(halted);
                    end
                end
                ST_STOPPING: begin
                    if (!stop_req) proto_q <= 1'b1;
                    if (grant_go)  state_q <= ST_GRANT;
                end
                ST_GRANT: begin
                    if (snoop_hit)     state_q <= ST_SNOOP;
                    else if (!stop_req) state_q <= idle_of(ret_halt_q);
                end
                ST_SNOOP: state_q <= ST_GRANT;
                default:  state_q <= ST_NORMAL;
            endcase
        end
    end

    assign state_code = state_q;
    assign proto_err  = proto_q;

endmodule

// File: rtl/stopclk_chk.sv
module stopclk_chk
    import stopclk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       stop_req,
    input logic       snoop_hit,
    input logic       ack_req,
    input logic [2:0] state_code,
    input logic       proto_err,
    input logic [3:0] evt_pend
);
    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> !ack_req);

    // R3
    ack_in_stopping_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> state_code == ST_STOPPING);

    // R5
    proto_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R6
    release_return_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_GRANT && !stop_req && !snoop_hit)
        |=> (state_code == ST_NORMAL || state_code == ST_HALT));

    // R7
    snoop_back_chk: assert property (@(posedge clk) disable iff (rst)
        state_code == ST_SNOOP |=> state_code == ST_GRANT);

    // R7
    snoop_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_GRANT && snoop_hit) |=> state_code == ST_SNOOP);

    // R8
    pend_once_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_pend != 4'b0) |=> (evt_pend == 4'b0));

endmodule

bind stopclk_ctrl stopclk_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .stop_req  (stop_req),
    .snoop_hit (snoop_hit),
    .ack_req   (ack_req),
    .state_code(state_code),
    .proto_err (proto_err),
    .evt_pend  (evt_pend)
);

// File: tb/stopclk_ctrl_tb.sv
module stopclk_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DELAY      = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop_req = 1'b0;
    logic       halted = 1'b0;
    logic       rsp_phase = 1'b0;
    logic       snoop_hit = 1'b0;
    logic [3:0] evt_in = 4'b0;
    logic       ack_req;
    logic [0:0] ack_die;
    logic [2:0] state_code;
    logic       proto_err;
    logic [3:0] evt_pend;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stopclk_ctrl #(.NUM_DIE(2), .GRANT_DELAY(DELAY)) u_dut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .halted(halted),
        .rsp_phase(rsp_phase), .snoop_hit(snoop_hit), .evt_in(evt_in),
        .ack_req(ack_req), .ack_die(ack_die), .state_code(state_code),
        .proto_err(proto_err), .evt_pend(evt_pend)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int idle_code(bit h);
        return h ? 1 : 0;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Drive from idle into grant; events ev_a pulsed while stopping
    task automatic enter_grant(input bit hlt, input bit early, input logic [3:0] ev_a,
                               input int d1, input int d2);
        halted = hlt; stop_req = 0;
        step();
        step();
        chk(state_code == idle_code(hlt), "R2 idle state", state_code, idle_code(hlt));
        stop_req = 1;
        step();
        chk(state_code == 2, "R3 stopping", state_code, 2);
        chk(ack_req == 1 && ack_die == 0, "R3 ack die0", {ack_req, ack_die}, 2);
        evt_in = ev_a;
        step();
        evt_in = 0;
        chk(ack_req == 0, "R3 single pulse", ack_req, 0);
        repeat (d1) step();
        rsp_phase = 1;
        step();
        rsp_phase = 0;
        chk(ack_req == 1 && ack_die == 1, "R3 ack die1", {ack_req, ack_die}, 3);
        step();
        chk(ack_req == 0, "R3 single pulse die1", ack_req, 0);
        repeat (d2) step();
        rsp_phase = 1;
        step();
        rsp_phase = 0;
        for (int k = 1; k < DELAY; k++) begin
            if (early && k == 3) stop_req = 0;
            if (early && k == 4) begin
                chk(proto_err == 1, "R5 early release flagged", proto_err, 1);
                stop_req = 1;
            end
            step();
        end
        chk(state_code == 2, "R4 still stopping at delay-1", state_code, 2);
        step();
        chk(state_code == 3, "R4 grant at delay", state_code, 3);
    endtask

    task automatic leave_grant(input bit hlt, input bit sar, input logic [3:0] exp_pend);
        stop_req = 0;
        if (sar) snoop_hit = 1;
        step();
        snoop_hit = 0;
        if (sar) begin
            chk(state_code == 4, "R7 snoop priority", state_code, 4);
            step();
            chk(state_code == 3, "R7 back to grant", state_code, 3);
            step();
        end
        chk(state_code == idle_code(hlt), "R6 return point", state_code, idle_code(hlt));
        chk(evt_pend == exp_pend, "R8 pending on return", evt_pend, exp_pend);
        step();
        chk(evt_pend == 0, "R8 one clock only", evt_pend, 0);
        evt_in = 4'hF;
        step();
        evt_in = 0;
        step();
        step();
        chk(evt_pend == 0, "R9 idle events ignored", evt_pend, 0);
    endtask

    task automatic run_stop(input bit hlt, input bit early, input int nsnoop, input bit sar,
                            input logic [3:0] ev_a, input logic [3:0] ev_b,
                            input int d1, input int d2);
        enter_grant(hlt, early, ev_a, d1, d2);
        evt_in = ev_b; step(); evt_in = 0; step();
        evt_in = ev_b; step(); evt_in = 0;
        for (int s = 0; s < nsnoop; s++) begin
            snoop_hit = 1;
            step();
            snoop_hit = 0;
            chk(state_code == 4, "R7 snoop state", state_code, 4);
            step();
            chk(state_code == 3, "R7 snoop return", state_code, 3);
        end
        chk(proto_err == early, "R5 sticky flag", proto_err, early);
        leave_grant(hlt, sar, ev_a | ev_b);
        rst = 1;
        step();
        rst = 0;
        chk(state_code == 0 && proto_err == 0, "R1 reset from idle",
            {state_code, proto_err}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (2) step();
        rst = 0;
        chk(state_code == 0, "R1 reset state", state_code, 0);
        chk(ack_req == 0 && proto_err == 0, "R1 reset flags", {ack_req, proto_err}, 0);
        chk(evt_pend == 0, "R1 reset pend", evt_pend, 0);

        run_stop(0, 0, 0, 0, 4'b0001, 4'b0100, 0, 0);
        run_stop(1, 0, 1, 0, 4'b0000, 4'b1010, 2, 3);
        run_stop(0, 1, 2, 0, 4'b1000, 4'b0001, 1, 0);
        run_stop(1, 0, 0, 1, 4'b0110, 4'b0110, 3, 1);

        // R10: reset while parked, entered from halt with early release
        enter_grant(1, 1, 4'b0101, 1, 1);
        evt_in = 4'b0010; step(); evt_in = 0;
        rst = 1;
        step();
        rst = 0;
        chk(state_code == 3, "R10 stays in grant", state_code, 3);
        chk(proto_err == 0, "R10 flag cleared", proto_err, 0);
        halted = 0;
        stop_req = 0;
        step();
        chk(state_code == 0, "R10 return to running", state_code, 0);
        chk(evt_pend == 0, "R10 events cleared", evt_pend, 0);
        step();

        for (int i = 0; i < 30; i++) begin
            run_stop(1'($urandom % 2), ($urandom % 4) == 0, int'($urandom % 3),
                     ($urandom % 4) == 0, 4'($urandom), 4'($urandom),
                     int'($urandom % 4), int'($urandom % 4));
        end
        summary();
    end

endmodule